// File: doc/BRIEF.md
# Radix-4 FFT Memory Address Generator

This block sequences a memory-based radix-4 FFT that has one butterfly engine and four two-port data banks, each allowing one read and one write per clock. A single start request launches a complete transform. The block then steps through every butterfly of every pass, one per cycle, using a pass field and a butterfly field. It emits one bank address per cycle, and all four banks use that same address. It also emits one address for the three twiddle-factor ROMs, the current pass number and a three-bit select for the external reorder network.

The bank address is the butterfly count rotated right by twice the pass number. The twiddle address is the butterfly count with its lowest 2p bits forced to zero. Both are built with wiring and a per-pass multiplexer, so no adder sits on the address path. The write address for the in-place result is the read address, with its valid and last-item flags, delayed by the fixed butterfly latency. A one-cycle done pulse follows the final write. The size is set by `LOG4N` (N = 4^LOG4N, LOG4N of at least 3), which gives `2*LOG4N-2` butterfly bits.

Top module: `fft4_addr_gen`

## Requirements
- R1: While reset is held and after it is released, with no start request, `busy`, `rd_valid`, `wr_valid` and `done` are 0 and `rd_addr`, `tw_addr`, `pass_num` are 0.
- R2: A start sampled high while `busy` is 0 makes `rd_valid` 1 in the next cycle, with pass 0 and butterfly index 0.
- R3: During a run the butterfly index rises by one every cycle and wraps from all-ones to zero. At each wrap `pass_num` rises by one. A run lasts exactly LOG4N * 2^(2*LOG4N-2) cycles, the pass order is 0 to LOG4N-1, and `rd_valid` drops afterwards.
- R4: `rd_addr` bit i equals butterfly-index bit ((i + 2p) mod (2*LOG4N-2)), where p is `pass_num`. This is a right rotation by 2p.
- R5: `tw_addr` equals the butterfly index with bits 2p-1..0 cleared. In the last pass it is all zero.
- R6: `reorder_sel` equals the three least significant bits of the butterfly index, bit 0 first, for every N.
- R7: `wr_valid` and `wr_addr` repeat `rd_valid` and `rd_addr` exactly PIPE_LAT cycles later.
- R8: `done` is high for exactly one cycle, the cycle after the final write of the last pass.
- R9: A start request is ignored while `busy` is 1, whether the read sequence is still running or writes are still draining. The address stream continues unchanged.
- R10: R2 to R8 hold for every LOG4N of at least 3. A new run may start in the very cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request to begin a transform, accepted only when idle |
| busy | output | 1 | Run in progress or writes still draining |
| rd_valid | output | 1 | Read address valid this cycle |
| rd_addr | output | 2*LOG4N-2 | Read address shared by the four data banks |
| wr_valid | output | 1 | Write address valid this cycle |
| wr_addr | output | 2*LOG4N-2 | Write address shared by the four data banks |
| tw_addr | output | 2*LOG4N-2 | Address shared by the three twiddle ROMs |
| pass_num | output | clog2(LOG4N) | Current pass number |
| reorder_sel | output | 3 | Select for the external reorder network |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The hardest situation to reach from the ports is a start request that arrives while the read side has already finished but the write pipeline is still draining. It lasts only PIPE_LAT cycles. The stimulus pulses start in the first cycle after the last read, and again in the middle of a run. The scoreboard then requires the original stream to finish untouched, with no extra items. A second start issued in the same cycle as `done` checks that a new run can follow back to back. Both checks run for two transform sizes.

// File: rtl/fft4_agen_pkg.sv
package fft4_agen_pkg;

  localparam int SEL_W = 3;

  function automatic int pass_bits(input int log4n);
    return (log4n < 2) ? 1 : $clog2(log4n);
  endfunction

endpackage

// File: rtl/fft4_step_ctr.sv
module fft4_step_ctr
  import fft4_agen_pkg::*;
#(
  parameter int LOG4N = 3,
  parameter int BW    = 2 * LOG4N - 2,
  parameter int PW    = pass_bits(LOG4N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  output logic          run,
  output logic [BW-1:0] bfly,
  output logic [PW-1:0] pass,
  output logic          last_step
);

  localparam logic [BW-1:0] B_LAST = '1;
  localparam logic [PW-1:0] P_LAST = PW'(LOG4N - 1);

  logic          run_q, run_d;
  logic [BW-1:0] b_q, b_d;
  logic [PW-1:0] p_q, p_d;
  logic          step_en;

  assign step_en = launch | run_q;

  always_comb begin
    run_d = run_q;
    b_d   = b_q;
    p_d   = p_q;
    if (launch) begin
      run_d = 1'b1;
      b_d   = '0;
      p_d   = '0;
    end else if (run_q) begin
      b_d = b_q + BW'(1);
      if (b_q == B_LAST) begin
        if (p_q == P_LAST) begin
          run_d = 1'b0;
          p_d   = '0;
        end else begin
          p_d = p_q + PW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      b_q   <= '0;
      p_q   <= '0;
    end else if (step_en) begin
      run_q <= run_d;
      b_q   <= b_d;
      p_q   <= p_d;
    end
  end

  assign run       = run_q;
  assign bfly      = b_q;
  assign pass      = p_q;
  assign last_step = run_q & (b_q == B_LAST) & (p_q == P_LAST);

  AST_LAUNCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (run_q && b_q == '0 && p_q == '0)); // R2
  AST_BFLY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !launch && b_q == B_LAST && p_q != P_LAST) |=> (b_q == '0 && p_q == $past(p_q) + PW'(1))); // R3
  AST_PASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (p_q <= P_LAST)); // R3
  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !launch && b_q == B_LAST && p_q == P_LAST) |=> !run_q); // R3

endmodule

// File: rtl/fft4_addr_map.sv
module fft4_addr_map
  import fft4_agen_pkg::*;
#(
  parameter int LOG4N = 3,
  parameter int BW    = 2 * LOG4N - 2,
  parameter int PW    = pass_bits(LOG4N)
) (
  input  logic [BW-1:0] bfly,
  input  logic [PW-1:0] pass,
  output logic [BW-1:0] rd_addr,
  output logic [BW-1:0] tw_addr
);

  logic [BW-1:0] rot_opt [LOG4N];
  logic [BW-1:0] tw_opt  [LOG4N];

  for (genvar k = 0; k < LOG4N; k++) begin : g_pass
    logic [BW-1:0] rot_w;
    logic [BW-1:0] tw_w;
    for (genvar i = 0; i < BW; i++) begin : g_bit
      assign rot_w[i] = bfly[(i + 2 * k) % BW];
      if (i >= 2 * k) begin : g_keep
        assign tw_w[i] = bfly[i];
      end else begin : g_clear
        assign tw_w[i] = 1'b0;
      end
    end
    assign rot_opt[k] = rot_w;
    assign tw_opt[k]  = tw_w;
  end

  always_comb begin
    rd_addr = '0;
    tw_addr = '0;
    for (int k = 0; k < LOG4N; k++) begin
      if (pass == PW'(k)) begin
        rd_addr = rot_opt[k];
        tw_addr = tw_opt[k];
      end
    end
  end

endmodule

// File: rtl/fft4_wr_pipe.sv
module fft4_wr_pipe #(
  parameter int W     = 4,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_last,
  input  logic [W-1:0] in_addr,
  output logic         out_valid,
  output logic         out_last,
  output logic [W-1:0] out_addr,
  output logic         any_valid
);

  logic [DEPTH-1:0] v_q;
  logic [DEPTH-1:0] l_q;
  logic [W-1:0]     a_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic         src_v;
    logic         src_l;
    logic [W-1:0] src_a;
    if (s == 0) begin : g_head
      assign src_v = in_valid;
      assign src_l = in_last;
      assign src_a = in_addr;
    end else begin : g_body
      assign src_v = v_q[s-1];
      assign src_l = l_q[s-1];
      assign src_a = a_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[s] <= 1'b0;
        l_q[s] <= 1'b0;
      end else begin
        v_q[s] <= src_v;
        l_q[s] <= src_v & src_l;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q[s] <= '0;
      end else if (src_v) begin
        a_q[s] <= src_a;
      end
    end
  end

  assign out_valid = v_q[DEPTH-1];
  assign out_last  = l_q[DEPTH-1];
  assign out_addr  = a_q[DEPTH-1];
  assign any_valid = |v_q;

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R8

endmodule

// File: rtl/fft4_addr_gen.sv
module fft4_addr_gen
  import fft4_agen_pkg::*;
#(
  parameter int LOG4N    = 3,
  parameter int PIPE_LAT = 3,
  localparam int BW      = 2 * LOG4N - 2,
  localparam int PW      = pass_bits(LOG4N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             rd_valid,
  output logic [BW-1:0]    rd_addr,
  output logic             wr_valid,
  output logic [BW-1:0]    wr_addr,
  output logic [BW-1:0]    tw_addr,
  output logic [PW-1:0]    pass_num,
  output logic [SEL_W-1:0] reorder_sel,
  output logic             done
);

  logic          run;
  logic [BW-1:0] bfly;
  logic [PW-1:0] pass;
  logic          last_step;
  logic          launch;
  logic          pipe_busy;
  logic          wr_last;
  logic          done_q, done_d;

  assign busy   = run | pipe_busy;
  assign launch = start & ~busy;

  fft4_step_ctr #(.LOG4N(LOG4N), .BW(BW), .PW(PW)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .run       (run),
    .bfly      (bfly),
    .pass      (pass),
    .last_step (last_step)
  );

  fft4_addr_map #(.LOG4N(LOG4N), .BW(BW), .PW(PW)) u_map (
    .bfly    (bfly),
    .pass    (pass),
    .rd_addr (rd_addr),
    .tw_addr (tw_addr)
  );

  fft4_wr_pipe #(.W(BW), .DEPTH(PIPE_LAT)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (run),
    .in_last   (last_step),
    .in_addr   (rd_addr),
    .out_valid (wr_valid),
    .out_last  (wr_last),
    .out_addr  (wr_addr),
    .any_valid (pipe_busy)
  );

  assign done_d = wr_valid & wr_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign rd_valid    = run;
  assign pass_num    = pass;
  assign reorder_sel = bfly[SEL_W-1:0];
  assign done        = done_q;

  AST_TW_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((tw_addr & ((BW'(1) << (2 * pass_num)) - BW'(1))) == '0)); // R5
  AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($countones(rd_addr) == $countones(bfly))); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && run && !last_step) |=> (run && bfly == $past(bfly) + BW'(1))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_valid && !wr_valid)); // R8

endmodule

// File: tb/fft4_addr_gen_test.sv
module fft4_addr_gen_lane #(
  parameter int LOG4N    = 3,
  parameter int PIPE_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_cmp,
  output int   n_bad,
  output logic fin
);

  localparam int BW  = 2 * LOG4N - 2;
  localparam int PW  = fft4_agen_pkg::pass_bits(LOG4N);
  localparam int NB  = 1 << BW;
  localparam int TOT = LOG4N * NB;
  localparam int MSK = NB - 1;

  typedef struct {
    int cyc;
    int addr;
    int tw;
    int pass;
    int sel;
  } item_t;

  logic          start;
  logic          busy, rd_valid, wr_valid, done;
  logic [BW-1:0] rd_addr, wr_addr, tw_addr;
  logic [PW-1:0] pass_num;
  logic [2:0]    reorder_sel;

  item_t rdq[$];
  item_t wrq[$];
  int    cyc;
  int    done_exp[$];
  int    done_cnt;
  int    cnt, bad;

  assign n_cmp = cnt;
  assign n_bad = bad;

  fft4_addr_gen #(.LOG4N(LOG4N), .PIPE_LAT(PIPE_LAT)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .rd_valid    (rd_valid),
    .rd_addr     (rd_addr),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .tw_addr     (tw_addr),
    .pass_num    (pass_num),
    .reorder_sel (reorder_sel),
    .done        (done)
  );

  function automatic int rotr(input int b, input int sh);
    return ((b >> sh) | (b << (BW - sh))) & MSK;
  endfunction

  function automatic int twmask(input int b, input int p);
    return ((b >> (2 * p)) << (2 * p)) & MSK;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    cnt++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s N=4^%0d %s: actual %0d expected %0d", req, LOG4N, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (rdq.size() == 0) begin
          chk("R9", "unexpected read item", 1, 0);
        end else begin
          item_t e;
          e = rdq.pop_front();
          chk("R3", "read cycle", cyc, e.cyc);
          chk("R3", "pass_num", int'(pass_num), e.pass);
          chk("R4", "rd_addr", int'(rd_addr), e.addr);
          chk("R5", "tw_addr", int'(tw_addr), e.tw);
          chk("R6", "reorder_sel", int'(reorder_sel), e.sel);
        end
      end
      if (wr_valid) begin
        if (wrq.size() == 0) begin
          chk("R7", "unexpected write item", 1, 0);
        end else begin
          item_t e;
          e = wrq.pop_front();
          chk("R7", "write cycle", cyc, e.cyc);
          chk("R7", "wr_addr", int'(wr_addr), e.addr);
        end
      end
      if (done) begin
        done_cnt++;
        if (done_exp.size() == 0) chk("R8", "unexpected done", 1, 0);
        else chk("R8", "done cycle", cyc, done_exp.pop_front());
      end
    end
  end

  // driver: pushes the expected stream, then pulses start
  task automatic launch_run(input bit poke);
    int c0;
    c0 = cyc;
    for (int p = 0; p < LOG4N; p++) begin
      for (int b = 0; b < NB; b++) begin
        item_t it;
        int i;
        i = p * NB + b;
        it.cyc  = c0 + 1 + i;
        it.addr = rotr(b, 2 * p);
        it.tw   = twmask(b, p);
        it.pass = p;
        it.sel  = b & 7;
        rdq.push_back(it);
        it.cyc = c0 + 1 + i + PIPE_LAT;
        wrq.push_back(it);
      end
    end
    done_exp.push_back(c0 + TOT + PIPE_LAT + 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: start mid-run and again while the writes drain
      for (int k = 1; k <= TOT + 1; k++) begin
        start = (k == 5) || (k == TOT + 1);
        @(negedge clk);
      end
      start = 1'b0;
    end
  endtask

  initial begin
    int d0;
    start    = 1'b0;
    fin      = 1'b0;
    cnt      = 0;
    bad      = 0;
    done_cnt = 0;
    @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "done in reset", int'(done), 0);
    wait (rst_n === 1'b1);
    @(negedge clk);
    @(negedge clk);
    chk("R1", "busy idle", int'(busy), 0);
    chk("R1", "rd_valid idle", int'(rd_valid), 0);
    chk("R1", "wr_valid idle", int'(wr_valid), 0);
    chk("R1", "rd_addr idle", int'(rd_addr), 0);
    chk("R1", "tw_addr idle", int'(tw_addr), 0);
    chk("R1", "pass_num idle", int'(pass_num), 0);

    // R2: plain run from idle
    launch_run(1'b0);
    chk("R2", "rd_valid after start", int'(rd_valid), 1);
    chk("R2", "first pass", int'(pass_num), 0);
    wait (done_cnt == 1);
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R3", "idle after run", int'(busy), 0);

    // R9: starts while busy must change nothing
    launch_run(1'b1);
    wait (done_cnt == 2);
    d0 = cyc;
    // R10: back-to-back run started in the done cycle
    chk("R8", "done high", int'(done), 1);
    launch_run(1'b0);
    chk("R10", "restart on done", cyc - d0, 1);
    wait (done_cnt == 3);
    @(negedge clk);
    chk("R8", "done single cycle", int'(done), 0);
    repeat (PIPE_LAT + 4) @(negedge clk);
    chk("R3", "read queue drained", rdq.size(), 0);
    chk("R7", "write queue drained", wrq.size(), 0);
    chk("R8", "done count", done_cnt, 3);
    chk("R9", "busy at end", int'(busy), 0);
    fin = 1'b1;
  end

endmodule

module fft4_addr_gen_test;

  logic clk;
  logic rst_n;
  int   c_a, b_a, c_b, b_b;
  logic f_a, f_b;
  int   wd;
  bit   timed_out;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // R10: two transform sizes, N = 64 and N = 256
  fft4_addr_gen_lane #(.LOG4N(3), .PIPE_LAT(3)) lane_a (
    .clk(clk), .rst_n(rst_n), .n_cmp(c_a), .n_bad(b_a), .fin(f_a));
  fft4_addr_gen_lane #(.LOG4N(4), .PIPE_LAT(2)) lane_b (
    .clk(clk), .rst_n(rst_n), .n_cmp(c_b), .n_bad(b_b), .fin(f_b));

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    timed_out = 1'b0;
    wd = 0;
    while (!(f_a === 1'b1 && f_b === 1'b1) && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (wd >= 20000) begin
      timed_out = 1'b1;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
    end
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             c_a + c_b + (timed_out ? 1 : 0), b_a + b_b + (timed_out ? 1 : 0));
    $finish;
  end

endmodule